// File: doc/BRIEF.md
# Focal Plane Readout Scan Controller

This block drives the row and column addressing of an X-Y addressable imaging array. The default array is 640 columns by 480 rows. Software-side logic programs a rectangular readout window through one shared command port. Each command word carries a value, a bit that picks the horizontal or the vertical axis, and a bit that picks the start or the stop edge. The controller then scans that window line by line. On every line it strobes each column of the window in turn. At the end of each line it issues a row-reset strobe to a second row pointer that runs ahead of the read pointer. The lead of that pointer, counted in line periods, sets the exposure of each pixel electronically, with no mechanical shutter.

Rows are read either in plain top-to-bottom order or in two fields. The interlaced order reads every second row of the window first, then the rows in between. A staged window, scan order and exposure become active together at the next frame boundary. No frame is ever read with a mix of two settings. Small windows give high frame rates, for example 133 by 142 pixels. The full array gives the slowest rate.

Top module: `fpa_scan_ctrl`

## Requirements
- R1: After reset `err` is low, the active window is the whole array (columns 0..COLS-1, rows 0..ROWS-1), order is progressive and exposure is the full frame height; the first frame starts at once.
- R2: A command word with `cmd_valid` high is routed by `cmd_vert` (0 = horizontal axis, 1 = vertical axis) and `cmd_stop` (0 = start edge, 1 = stop edge), and `cmd_data` is the address; the window spans start to stop inclusive on each axis.
- R3: Each line lasts W + HGAP clocks, where W is the window width. `col_en` is high for the first W clocks, while `col_addr` counts up by one from the horizontal start. `line_sync` is high for exactly the first clock of the line.
- R4: In progressive order, line k of a frame reads row `vstart + k` on `row_addr`, held for the whole line.
- R5: In interlaced order, with N window rows, the first ceil(N/2) lines read rows vstart, vstart+2, vstart+4, and so on; the remaining lines read vstart+1, vstart+3, and so on.
- R6: `frame_sync` is high for the whole first line of each frame and low on every other line; frames follow each other with no gap.
- R7: `row_rst` pulses for one clock on the last clock of every line, with `row_rst_addr` equal to the row read E lines later in the read sequence, wrapping into the next frame's sequence under the current settings.
- R8: The exposure E is taken from `cfg_exp_lines` at the frame boundary. A value of 0 or 1 gives E = 1. A value above the window height N gives E = N, so the reset row is the row just read.
- R9: A stop value at or below the staged start, a stop value outside the array, or a start value at or above the staged stop is rejected. The staged edge keeps its old value and `err` goes high on the next clock. `err` stays high until the next accepted write clears it.
- R10: Window writes and changes on `cfg_interlace` or `cfg_exp_lines` during a frame do not alter that frame; they take effect from the next frame start.
- R11: A reduced window of 133 columns by 142 rows is scanned with the same line and frame rules as the full array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one column per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_vert | input | 1 | Axis select: 0 horizontal, 1 vertical |
| cmd_stop | input | 1 | Edge select: 0 start, 1 stop |
| cmd_data | input | AW | Address value of the command |
| cfg_interlace | input | 1 | Row order for the next frame: 1 interlaced, 0 progressive |
| cfg_exp_lines | input | EW | Exposure for the next frame, in line periods |
| col_en | output | 1 | Column strobe valid |
| col_addr | output | CW | Selected column |
| line_sync | output | 1 | First clock of each column scan |
| row_addr | output | RW | Row being read |
| frame_sync | output | 1 | High during the first line of a frame |
| row_rst | output | 1 | Row-reset strobe |
| row_rst_addr | output | RW | Row being reset |
| err | output | 1 | Last window write was rejected |

## Verification
The bench scans windows with an odd and an even row count in interlaced order. It checks the split point between the two fields. An off-by-one there would repeat a row or skip the last row of the first field. It drives exposure values of 0, 1 and above the window height. A missing clamp would point the reset at a row outside the window, or skew the reset pointer by a line. It writes a new window and scan order early in a frame and checks that frame in full, so a design that loads settings at once would show a torn frame. It also sends stop values equal to the start and past the array edge, then checks that the next frame still uses the old window and that one accepted write clears the flag.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // Command target selected by {vertical, stop} bits of a command word.
  typedef enum logic [1:0] {
    TGT_HSTART = 2'b00,
    TGT_HSTOP  = 2'b01,
    TGT_VSTART = 2'b10,
    TGT_VSTOP  = 2'b11
  } scan_tgt_e;
endpackage

// File: rtl/scan_axis_reg.sv
// Staged start/stop pair for one axis, with range checking of each write.
module scan_axis_reg #(
  parameter int SIZE = 640,
  parameter int VW   = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_start,
  input  logic          wr_stop,
  input  logic [VW-1:0] val,
  output logic [VW-1:0] start_q,
  output logic [VW-1:0] stop_q,
  output logic          ok,
  output logic          bad
);
  localparam logic [VW:0] LIMIT = (VW+1)'(SIZE);

  logic start_ok, stop_ok;

  always_comb begin
    start_ok = val < stop_q;
    stop_ok  = (val > start_q) && ({1'b0, val} < LIMIT);
    ok  = (wr_start && start_ok) || (wr_stop && stop_ok);
    bad = (wr_start && !start_ok) || (wr_stop && !stop_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      stop_q  <= VW'(SIZE - 1);
    end else if (wr_start && start_ok) begin
      start_q <= val;
    end else if (wr_stop && stop_ok) begin
      stop_q <= val;
    end
  end
endmodule

// File: rtl/scan_row_map.sv
// Maps a line index within the frame to a row offset inside the window.
module scan_row_map #(
  parameter int RW = 9
) (
  input  logic [RW-1:0] idx,
  input  logic [RW+1:0] n,
  input  logic          il,
  output logic [RW-1:0] off
);
  localparam int NW = RW + 2;

  logic [NW-1:0] half, idx_x;

  always_comb begin
    half  = (n + NW'(1)) >> 1;
    idx_x = NW'(idx);
    if (il && (idx_x >= half))
      off = RW'(((idx_x - half) << 1) + NW'(1));
    else if (il)
      off = RW'(idx_x << 1);
    else
      off = idx;
  end
endmodule

// File: rtl/fpa_scan_ctrl.sv
module fpa_scan_ctrl
  import scan_pkg::*;
#(
  parameter int COLS = 640,
  parameter int ROWS = 480,
  parameter int HGAP = 4,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS),
  localparam int AW = (CW > RW) ? CW : RW,
  localparam int EW = RW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_vert,
  input  logic          cmd_stop,
  input  logic [AW-1:0] cmd_data,
  input  logic          cfg_interlace,
  input  logic [EW-1:0] cfg_exp_lines,
  output logic          col_en,
  output logic [CW-1:0] col_addr,
  output logic          line_sync,
  output logic [RW-1:0] row_addr,
  output logic          frame_sync,
  output logic          row_rst,
  output logic [RW-1:0] row_rst_addr,
  output logic          err
);
  localparam int LW = CW + 2;
  localparam int NW = RW + 2;

  // ---------------- command decode and staged window ----------------
  scan_tgt_e     tgt;
  logic [AW-1:0] st_q [2];
  logic [AW-1:0] sp_q [2];
  logic          acc  [2];
  logic          rej  [2];

  assign tgt = scan_tgt_e'({cmd_vert, cmd_stop});

  for (genvar g = 0; g < 2; g++) begin : g_axis
    localparam int SZ = (g == 0) ? COLS : ROWS;
    localparam scan_tgt_e T_ST = (g == 0) ? TGT_HSTART : TGT_VSTART;
    localparam scan_tgt_e T_SP = (g == 0) ? TGT_HSTOP  : TGT_VSTOP;
    scan_axis_reg #(.SIZE(SZ), .VW(AW)) u_axis (
      .clk      (clk),
      .rst      (rst),
      .wr_start (cmd_valid && (tgt == T_ST)),
      .wr_stop  (cmd_valid && (tgt == T_SP)),
      .val      (cmd_data),
      .start_q  (st_q[g]),
      .stop_q   (sp_q[g]),
      .ok       (acc[g]),
      .bad      (rej[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                     err <= 1'b0;
    else if (rej[0] || rej[1])   err <= 1'b1;
    else if (acc[0] || acc[1])   err <= 1'b0;
  end

  // ---------------- settings for the next frame ----------------
  logic [LW-1:0] w_nx;
  logic [NW-1:0] n_nx, e_nx;

  always_comb begin
    w_nx = LW'(sp_q[0]) - LW'(st_q[0]) + LW'(1);
    n_nx = NW'(sp_q[1]) - NW'(st_q[1]) + NW'(1);
    if (cfg_exp_lines <= EW'(1))  e_nx = NW'(1);
    else if (cfg_exp_lines > n_nx) e_nx = n_nx;
    else                           e_nx = cfg_exp_lines;
  end

  // ---------------- active settings and scan counters ----------------
  logic [CW-1:0] hs_a;
  logic [LW-1:0] w_a;
  logic [RW-1:0] vs_a;
  logic [NW-1:0] n_a, e_a;
  logic          il_a;
  logic [LW-1:0] c;
  logic [RW-1:0] k;
  logic          line_last, frame_last;

  assign line_last  = (c == w_a + LW'(HGAP - 1));
  assign frame_last = line_last && (NW'(k) == n_a - NW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      c    <= '0;
      k    <= '0;
      hs_a <= '0;
      w_a  <= LW'(COLS);
      vs_a <= '0;
      n_a  <= NW'(ROWS);
      e_a  <= NW'(ROWS);
      il_a <= 1'b0;
    end else if (line_last) begin
      c <= '0;
      if (frame_last) begin
        k    <= '0;
        hs_a <= CW'(st_q[0]);
        w_a  <= w_nx;
        vs_a <= RW'(st_q[1]);
        n_a  <= n_nx;
        e_a  <= e_nx;
        il_a <= cfg_interlace;
      end else begin
        k <= k + RW'(1);
      end
    end else begin
      c <= c + LW'(1);
    end
  end

  // ---------------- read and reset row pointers ----------------
  logic [NW-1:0] j_sum, j_wrap;
  logic [RW-1:0] idx_in [2];
  logic [RW-1:0] off    [2];

  always_comb begin
    j_sum  = NW'(k) + e_a;
    j_wrap = (j_sum >= n_a) ? (j_sum - n_a) : j_sum;
  end

  assign idx_in[0] = k;
  assign idx_in[1] = RW'(j_wrap);

  for (genvar m = 0; m < 2; m++) begin : g_map
    scan_row_map #(.RW(RW)) u_map (
      .idx (idx_in[m]),
      .n   (n_a),
      .il  (il_a),
      .off (off[m])
    );
  end

  // ---------------- registered strobes ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      col_en       <= 1'b0;
      col_addr     <= '0;
      line_sync    <= 1'b0;
      row_addr     <= '0;
      frame_sync   <= 1'b0;
      row_rst      <= 1'b0;
      row_rst_addr <= '0;
    end else begin
      col_en       <= c < w_a;
      col_addr     <= hs_a + CW'(c);
      line_sync    <= (c == '0);
      row_addr     <= vs_a + off[0];
      frame_sync   <= (k == '0);
      row_rst      <= line_last;
      row_rst_addr <= vs_a + off[1];
    end
  end
endmodule

// File: rtl/fpa_scan_ctrl_chk.sv
module fpa_scan_ctrl_chk #(
  parameter int COLS = 640,
  parameter int ROWS = 480,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS),
  localparam int AW = (CW > RW) ? CW : RW
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          col_en,
  input logic [CW-1:0] col_addr,
  input logic          line_sync,
  input logic [RW-1:0] row_addr,
  input logic          frame_sync,
  input logic          row_rst,
  input logic          err
);
  // R3
  line_start_chk: assert property (@(posedge clk) disable iff (rst)
    line_sync |-> (col_en && (int'(col_addr) < COLS)));

  // R3
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    (col_en && !line_sync) |-> ($past(col_en) && (col_addr == CW'($past(col_addr) + 1'b1))));

  // R7
  rst_then_line_chk: assert property (@(posedge clk) disable iff (rst)
    row_rst |=> line_sync);

  // R7
  rst_in_gap_chk: assert property (@(posedge clk) disable iff (rst)
    row_rst |-> !col_en);

  // R6
  fsync_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !line_sync |-> $stable(frame_sync));

  // R4
  row_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !line_sync |-> $stable(row_addr));

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(cmd_valid));
endmodule

bind fpa_scan_ctrl fpa_scan_ctrl_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .col_en     (col_en),
  .col_addr   (col_addr),
  .line_sync  (line_sync),
  .row_addr   (row_addr),
  .frame_sync (frame_sync),
  .row_rst    (row_rst),
  .err        (err)
);

// File: tb/fpa_scan_ctrl_test.sv
`timescale 1ns/1ps
module fpa_scan_ctrl_test;
  localparam int COLS = 160;
  localparam int ROWS = 150;
  localparam int HGAP = 4;
  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);
  localparam int AW = (CW > RW) ? CW : RW;
  localparam int EW = RW + 2;
  localparam int NV = 5;
  // hstart, hstop, vstart, vstop, interlace, exposure
  localparam int VEC [NV][6] = '{
    '{ 10, 142,   4, 145, 0,  10},   // 133x142 progressive
    '{ 20,  27,  30,  35, 1,   0},   // even rows interlaced, exposure 0
    '{  3,   9,   7,  11, 1,   3},   // odd rows interlaced
    '{100, 109,  50,  53, 0, 200},   // exposure above height
    '{150, 159, 140, 149, 0,   1}    // far corner
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_vert = 1'b0, cmd_stop = 1'b0;
  logic [AW-1:0] cmd_data = '0;
  logic cfg_interlace = 1'b0;
  logic [EW-1:0] cfg_exp_lines = '0;
  logic col_en, line_sync, frame_sync, row_rst, err;
  logic [CW-1:0] col_addr;
  logic [RW-1:0] row_addr, row_rst_addr;

  int tests = 0, fails = 0;
  bit done = 0;
  int m_st [2] = '{0, 0};
  int m_sp [2] = '{COLS-1, ROWS-1};

  always #2 clk = ~clk;

  fpa_scan_ctrl #(.COLS(COLS), .ROWS(ROWS), .HGAP(HGAP)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_vert(cmd_vert),
    .cmd_stop(cmd_stop), .cmd_data(cmd_data), .cfg_interlace(cfg_interlace),
    .cfg_exp_lines(cfg_exp_lines), .col_en(col_en), .col_addr(col_addr),
    .line_sync(line_sync), .row_addr(row_addr), .frame_sync(frame_sync),
    .row_rst(row_rst), .row_rst_addr(row_rst_addr), .err(err));

  task automatic check(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int rowof(input int k, input int n, input int vs, input int il);
    int h;
    h = (n + 1) / 2;
    if (il == 0) return vs + k;
    if (k < h) return vs + 2 * k;
    return vs + 2 * (k - h) + 1;
  endfunction

  task automatic wr(input int ax, input int st, input int val, input int exp_err, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_vert = ax[0]; cmd_stop = st[0]; cmd_data = AW'(val);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(int'(err) == exp_err, tag, int'(err), exp_err);
  endtask

  task automatic set_axis(input int ax, input int ns, input int np);
    if (ns < m_sp[ax]) begin
      wr(ax, 0, ns, 0, "R2 accepted start write");
      wr(ax, 1, np, 0, "R2 accepted stop write");
    end else begin
      wr(ax, 1, np, 0, "R2 accepted stop write");
      wr(ax, 0, ns, 0, "R2 accepted start write");
    end
    m_st[ax] = ns;
    m_sp[ax] = np;
  endtask

  task automatic apply(input int i);
    set_axis(0, VEC[i][0], VEC[i][1]);
    set_axis(1, VEC[i][2], VEC[i][3]);
    cfg_interlace = VEC[i][4][0];
    cfg_exp_lines = EW'(VEC[i][5]);
  endtask

  task automatic err_phase();
    wr(0, 1, 150, 1, "R9 stop equal to start rejected");
    wr(0, 1, 160, 1, "R9 stop past array edge rejected");
    wr(0, 1, 159, 0, "R9 accepted write clears flag");
    wr(1, 0, 149, 1, "R9 start at stop rejected");
    wr(1, 1, 200, 1, "R9 vertical stop past edge rejected");
  endtask

  task automatic wait_frame();
    do @(negedge clk); while (!(line_sync && frame_sync));
  endtask

  // Starts at the negedge showing the first line of a frame, ends at the
  // negedge showing the first line of the following frame.
  task automatic capture(input int hs, input int hp, input int vs, input int vp,
                         input int il, input int ex, output int bad);
    int n, w, ec, bc, br, bs, bf;
    n = vp - vs + 1; w = hp - hs + 1;
    ec = (ex <= 1) ? 1 : ((ex > n) ? n : ex);
    bc = 0; br = 0; bs = 0; bf = 0;
    for (int k = 0; k < n; k++) begin
      for (int t = 0; t < w + HGAP; t++) begin
        if (k != 0 || t != 0) @(negedge clk);
        if (line_sync != (t == 0)) bc++;
        if (t < w) begin
          if (!col_en || int'(col_addr) != hs + t) bc++;
        end else if (col_en) bc++;
        if (int'(row_addr) != rowof(k, n, vs, il)) br++;
        if (frame_sync != (k == 0)) bf++;
        if (row_rst != (t == w + HGAP - 1)) bs++;
        else if (row_rst && int'(row_rst_addr) != rowof((k + ec) % n, n, vs, il)) bs++;
      end
    end
    @(negedge clk);
    if (!(line_sync && frame_sync)) bf++;
    check(bc == 0, "R2 R3 column scan", bc, 0);
    check(br == 0, (il != 0) ? "R5 interlaced row order" : "R4 progressive row order", br, 0);
    check(bf == 0, "R6 frame sync", bf, 0);
    check(bs == 0, "R7 R8 row reset pointer", bs, 0);
    bad = bc + br + bf + bs;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (4) @(negedge clk);
    check(err == 1'b0, "R1 err low in reset", int'(err), 0);
    check(!col_en && !row_rst && !line_sync, "R1 strobes idle in reset",
          int'({col_en, row_rst, line_sync}), 0);
    rst = 1'b0;
    wait_frame();
    // R1 default full array frame, while R10 settings for the next frame arrive
    fork
      capture(0, COLS-1, 0, ROWS-1, 0, ROWS, bad);
      apply(0);
    join
    check(bad == 0, "R1 default full window after reset", bad, 0);
    for (int i = 0; i < NV; i++) begin
      fork
        capture(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5], bad);
        begin
          if (i < NV - 1) apply(i + 1);
          else err_phase();
        end
      join
      check(bad == 0, "R10 frame untouched by writes made during it", bad, 0);
      if (i == 0) check(bad == 0, "R11 reduced 133x142 window", bad, 0);
    end
    capture(VEC[NV-1][0], VEC[NV-1][1], VEC[NV-1][2], VEC[NV-1][3],
            VEC[NV-1][4], VEC[NV-1][5], bad);
    check(bad == 0, "R9 window kept after rejected writes", bad, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule